// File: doc/BRIEF.md
# UART Receive Byte Queue with Occupancy Bands

This block sits between a serial receiver and the host bus of a UART. The receiver hands it characters one byte at a time, and the host takes them out in arrival order. The queue holds up to 24 bytes. A packed status word tells the host the byte count, whether the queue is full, and which quarter of capacity the occupancy has reached. A level interrupt line rises once the occupancy reaches a threshold that the host has programmed.

The receive side is a valid/ready stream, but the serial receiver cannot be stalled. `in_ready` tells it whether a byte offered in this cycle will be stored. A byte offered while `in_ready` is low is not held for a retry. It is dropped, and the sticky overrun flag is set. When the queue is full, `in_ready` is high only if the host pops in the same cycle. The host side is also a valid/ready stream with first-word fall-through. `out_data` holds the oldest byte whenever `out_valid` is high, and the byte is consumed on a cycle in which both `out_valid` and `out_ready` are high.

The threshold is programmed through a write-only pin pair (`cfg_wr`, `cfg_thr`) and kept in its own register. The band field of the status word always reports occupancy, so reading status never disturbs the programmed threshold.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the queue is empty. `out_valid` is 0, the count is 0, the full bit is 0, the band is 00, the programmed threshold is 00, `level_irq` is 0 and the overrun flag is 0.
- R2: Bytes leave in the order they were accepted. `stat_rdata[4:0]` gives the stored byte count, from 0 to 24. `out_valid` is 1 exactly when the count is non-zero.
- R3: A cycle with `cfg_wr`=1 loads `cfg_thr` as the threshold. Value 00 keeps `level_irq` at 0. Values 01, 10 and 11 make `level_irq` 1 while the count is at least 6, 12 or 18 respectively.
- R4: `stat_rdata[7:6]` gives the occupancy band regardless of the programmed threshold. The codes are 00 for a count below 6, 01 for 6 or more, 10 for 12 or more, and 11 for 18 or more.
- R5: `stat_rdata[5]` (full) is 1 exactly when the count is 24. `gen_status[0]` always equals it. `in_ready` is 1 when the count is below 24, or when a pop is accepted in the same cycle.
- R6: A byte offered with `in_valid`=1 while `in_ready`=0 is discarded. The stored bytes and the count are unchanged.
- R7: `gen_status[1]` (overrun) is set by a discarded byte and holds until a cycle with `err_clr`=1 and no discard. A discard in the same cycle as `err_clr` leaves it set.
- R8: A push and a pop in the same cycle on a full queue both take effect. The popped byte is the oldest one, the new byte is queued last, and the count stays at 24.
- R9: `out_ready` while the queue is empty has no effect. The count stays 0, and a byte pushed in that cycle is the next one delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receiver offers a byte |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Offered byte will be stored this cycle |
| out_valid | output | 1 | Queue holds at least one byte |
| out_data | output | 8 | Oldest stored byte |
| out_ready | input | 1 | Host takes the oldest byte |
| cfg_wr | input | 1 | Load threshold selector |
| cfg_thr | input | 2 | Threshold selector: 00 off, 01/10/11 quarter steps |
| err_clr | input | 1 | Reset-error command, clears overrun |
| stat_rdata | output | 8 | {band[1:0], full, count[4:0]} |
| gen_status | output | 2 | General status: {overrun, full} |
| level_irq | output | 1 | Occupancy has reached the programmed threshold |

## Verification
The two functions that can coincide are a receiver push and a host pop. When the queue is full, their overlap decides whether the byte is accepted or dropped. A directed phase fills the queue to 24, offers bytes with and without a simultaneous pop, and issues `err_clr` in the same cycle as a drop. A long random phase then mixes pushes, pops, threshold writes and clears. A queue-based model judges every cycle. It compares the count, the band, the full and overrun bits, `in_ready`, the head byte and `level_irq` against what the model predicts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DEPTH = 24;
  localparam int unsigned RXF_DW    = 8;

  typedef enum logic [1:0] {
    BAND_LOW = 2'b00,
    BAND_Q1  = 2'b01,
    BAND_Q2  = 2'b10,
    BAND_Q3  = 2'b11
  } band_e;
endpackage

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DEPTH = 24,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_thr,
  input  logic [CW-1:0] count,
  output logic [1:0]    band,
  output logic          irq
);
  import rxf_pkg::*;
  localparam int QTR = DEPTH / 4;

  logic [1:0]    thr_q;
  logic [CW-1:0] thr_cnt;
  band_e         band_c;

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= 2'b00;
    else if (cfg_wr) thr_q <= cfg_thr;
  end

  always_comb begin
    band_c = BAND_LOW;
    for (int k = 1; k < 4; k++) begin
      if (count >= CW'(k * QTR)) band_c = band_e'(k[1:0]);
    end
  end

  assign thr_cnt = CW'(int'(thr_q) * QTR);
  assign band    = band_c;
  assign irq     = (thr_q != 2'b00) && (count >= thr_cnt);
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo #(
  parameter int DEPTH = rxf_pkg::RXF_DEPTH,
  parameter int DW    = rxf_pkg::RXF_DW,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_thr,
  input  logic          err_clr,
  output logic [CW+2:0] stat_rdata,
  output logic [1:0]    gen_status,
  output logic          level_irq
);
  logic [CW-1:0] count;
  logic [1:0]    band;
  logic          full, push, pop, drop, ovr_q;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign in_ready  = !full || pop;
  assign push      = in_valid && in_ready;
  assign drop      = in_valid && !in_ready;

  rxf_storage #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata(in_data), .rdata(out_data), .count(count)
  );

  rxf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_thr(cfg_thr),
    .count(count), .band(band), .irq(level_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (drop)    ovr_q <= 1'b1;
    else if (err_clr) ovr_q <= 1'b0;
  end

  assign stat_rdata = {band, full, count};
  assign gen_status = {ovr_q, full};
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 24,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          cfg_wr,
  input logic [1:0]    cfg_thr,
  input logic          err_clr,
  input logic [CW+2:0] stat_rdata,
  input logic [1:0]    gen_status,
  input logic          level_irq
);
  logic [CW-1:0] cnt;
  logic          fbit;
  logic [1:0]    bnd;
  assign cnt  = stat_rdata[CW-1:0];
  assign fbit = stat_rdata[CW];
  assign bnd  = stat_rdata[CW+2:CW+1];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_empty_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid);
  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_thr == 2'b00) |=> !level_irq);
  assert_irq_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_irq |-> (bnd != 2'b00));
  assert_full_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_status[0] == fbit);
  assert_drop_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (fbit && cnt == CW'(DEPTH)));
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_status[1] && !err_clr) |=> gen_status[1]);
  assert_pushpop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fbit && in_valid && out_ready) |=> fbit);
endmodule

bind rx_level_fifo rxf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .cfg_wr(cfg_wr),
  .cfg_thr(cfg_thr), .err_clr(err_clr), .stat_rdata(stat_rdata),
  .gen_status(gen_status), .level_irq(level_irq)
);

// File: tb/rx_level_fifo_tb.sv
module rx_level_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 24;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, cfg_wr = 0, err_clr = 0;
  logic [7:0] in_data = 0;
  logic [1:0] cfg_thr = 0;
  logic in_ready, out_valid, level_irq;
  logic [7:0] out_data, stat_rdata;
  logic [1:0] gen_status;

  int vectors = 0, misses = 0;
  bit done = 0;
  byte unsigned q[$];
  int thr = 0;
  bit ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_level_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .cfg_wr(cfg_wr), .cfg_thr(cfg_thr),
    .err_clr(err_clr), .stat_rdata(stat_rdata), .gen_status(gen_status),
    .level_irq(level_irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare after settling, update the model
  task automatic step(bit iv, byte unsigned id, bit ordy, bit cw, int ct, bit ec);
    int n, band, exp_rdy;
    bit popm;
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy;
    cfg_wr = cw; cfg_thr = 2'(ct); err_clr = ec;
    #1;
    n = q.size();
    band = (n >= 18) ? 3 : (n >= 12) ? 2 : (n >= 6) ? 1 : 0;
    exp_rdy = (n < DEPTH || ordy) ? 1 : 0;
    chk("R2", "count", int'(stat_rdata[4:0]), n);
    chk("R2", "out_valid", int'(out_valid), (n > 0) ? 1 : 0);
    if (n > 0) chk("R2", "out_data", int'(out_data), int'(q[0]));
    chk("R4", "band", int'(stat_rdata[7:6]), band);
    chk("R3", "level_irq", int'(level_irq), (thr != 0 && n >= 6 * thr) ? 1 : 0);
    chk("R5", "full", int'(stat_rdata[5]), (n == DEPTH) ? 1 : 0);
    chk("R5", "gen_full", int'(gen_status[0]), (n == DEPTH) ? 1 : 0);
    chk("R5", "in_ready", int'(in_ready), exp_rdy);
    chk("R7", "overrun", int'(gen_status[1]), int'(ovr));
    popm = ordy && n > 0;
    if (popm) void'(q.pop_front());
    if (iv && exp_rdy == 1) q.push_back(id);
    if (iv && exp_rdy == 0) ovr = 1;      // R6 discard, R7 set wins
    else if (ec) ovr = 0;
    if (cw) thr = ct;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: idle cycle right after reset
    step(0, 0, 0, 0, 0, 0);
    chk("R1", "reset_status", int'(stat_rdata), 0);
    chk("R1", "reset_gen", int'(gen_status), 0);
    // R9: pop on empty with a push in the same cycle
    step(1, 8'hA5, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    // R2/R6/R7: fill past capacity without popping
    step(0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 30; i++) step(1, 8'(i + 16), 0, 0, 0, 0);
    // R3: thresholds while full, then inhibited
    step(0, 0, 0, 1, 2, 0);
    step(0, 0, 0, 1, 3, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R7: clear in the same cycle as a drop keeps overrun, then clear alone
    step(1, 8'h77, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R8: push + pop on a full queue
    for (int i = 0; i < 5; i++) step(1, 8'(200 + i), 1, 0, 0, 0);
    // drain with threshold 10 so level_irq falls at 11
    step(0, 0, 0, 1, 2, 0);
    for (int i = 0; i < 26; i++) step(0, 0, 1, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 60, 8'($urandom), ($urandom_range(0, 99) < 45),
           ($urandom_range(0, 99) < 4), int'($urandom_range(0, 3)),
           ($urandom_range(0, 99) < 3));
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule